// File: doc/BRIEF.md
# Thermal Throttle Activation Controller

This block decides when a thermal throttling circuit is engaged and asks the clock and voltage logic around it to step down to a lower operating point or back up to the previous one. Throttling can be started in two ways: by the over-temperature comparator while automatic mode is enabled, or by software setting the demand bit of a small control register through a bit-write port. When both sources want throttling, the automatic source owns the episode.

After a temperature-driven step down, the block runs a fixed wait of `WAIT_CYCLES` clocks. When the wait expires it checks the comparator again. If the die is still hot, it stays throttled and starts another wait. If the die has cooled and software is not asking for throttling, it requests a step up. Every step down and every step up raises a one-cycle interrupt pulse, and a status output records which way the last transition went.

The controller has three states. `TT_RUN` is unthrottled. `TT_DEMAND` is throttled because software asked for it. `TT_AUTO` is throttled because of temperature, with the wait timer running. The transitions are:
- RUN→AUTO (step down) on a hot comparator with automatic mode enabled.
- RUN→DEMAND (step down) when the demand bit is set.
- DEMAND→AUTO (no pulse) when the comparator goes hot with automatic mode enabled.
- DEMAND→RUN (step up) when the demand bit is cleared.
- AUTO→AUTO (the wait restarts) when the wait expires while still hot.
- AUTO→DEMAND (no pulse) when the wait expires after cooling and the demand bit is set.
- AUTO→RUN (step up) when the wait expires after cooling and the demand bit is clear.

Top module: `thermal_throttle_ctl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `throttle_o`, `step_down_o`, `step_up_o`, `irq_o` and `irq_dir_o` are all 0.
- R2: In the unthrottled state, a write of value 1 to bit index 4 (`ctl_wr_i`=1, `ctl_bit_i`=4, `ctl_val_i`=1) makes `throttle_o` 1 and `step_down_o` a one-cycle pulse in the cycle after the write edge, whatever the level of `hot_i`.
- R3: Writes to any bit index other than 4 have no effect on throttling or on the stored demand bit.
- R4: While throttling is held only by the demand bit, a write of value 0 to bit index 4 makes `throttle_o` 0 and `step_up_o` a one-cycle pulse in the cycle after the write edge.
- R5: In the unthrottled state, `hot_i`=1 with `auto_en_i`=1 at a clock edge starts throttling with a step-down pulse in the next cycle. `hot_i` with `auto_en_i`=0 does not.
- R6: While automatic mode owns throttling, writing 0 to bit index 4 does not end it. A hot comparator with automatic mode enabled during demand throttling moves ownership to automatic mode with no pulse, and the wait starts.
- R7: A temperature-driven episode lasts exactly `WAIT_CYCLES` cycles from its step down, counted from ownership by automatic mode. If the comparator is cold at expiry and the demand bit is 0, a step-up pulse follows.
- R8: If `hot_i` and `auto_en_i` are both 1 at the expiry edge, throttling continues with no pulse and a fresh wait of `WAIT_CYCLES` cycles begins.
- R9: If the wait expires cold while the demand bit is 1, throttling continues with no pulse under demand ownership until the bit is written to 0.
- R10: `irq_o` pulses for exactly the cycles in which `step_down_o` or `step_up_o` pulses. `irq_dir_o` becomes 1 with a step down and 0 with a step up, and holds its value in between.
- R11: `step_down_o` and `step_up_o` are never 1 in the same cycle, and neither stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hot_i | input | 1 | Over-temperature comparator output |
| auto_en_i | input | 1 | Automatic (temperature-driven) mode enable |
| ctl_wr_i | input | 1 | Control register bit-write strobe |
| ctl_bit_i | input | IDX_W (3) | Bit index addressed by the write |
| ctl_val_i | input | 1 | Value written to the addressed bit |
| throttle_o | output | 1 | Throttling circuit active |
| step_down_o | output | 1 | One-cycle request to go to the lower operating point |
| step_up_o | output | 1 | One-cycle request to return to the previous operating point |
| irq_o | output | 1 | One-cycle interrupt on every transition |
| irq_dir_o | output | 1 | Direction of the last transition: 1 down, 0 up |

## Verification
A wrong state encoding or a wrong ownership decision shows up at the ports within one cycle. Examples are a missing or extra step pulse, or `throttle_o` dropping on a write that automatic mode should have overridden. A wrong wait counter shows up only at expiry, as a step up that comes early or late by the counting error, or a missed restart while the comparator is still hot. For that reason the episodes are run to and past their full length. The behavioural model is compared with every output on every clock, so any such mistake is reported in the first cycle in which it changes a port.

// File: rtl/tt_pkg.sv
package tt_pkg;

    typedef enum logic [1:0] {
        TT_RUN    = 2'd0,
        TT_DEMAND = 2'd1,
        TT_AUTO   = 2'd2
    } tt_state_e;

endpackage

// File: rtl/tt_demand_reg.sv
module tt_demand_reg #(
    parameter int CTL_W      = 8,
    parameter int DEMAND_BIT = 4,
    localparam int IDX_W     = (CTL_W > 1) ? $clog2(CTL_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [IDX_W-1:0] bit_i,
    input  logic             val_i,
    output logic             demand_eff_o
);

    localparam logic [IDX_W-1:0] HIT_IDX = IDX_W'(DEMAND_BIT);

    logic demand_q;
    logic hit;

    assign hit          = wr_i && (bit_i == HIT_IDX);
    // A write takes effect in the same cycle so activation is immediate.
    assign demand_eff_o = hit ? val_i : demand_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            demand_q <= 1'b0;
        end else if (hit) begin
            demand_q <= val_i;
        end
    end

endmodule

// File: rtl/tt_wait_timer.sv
module tt_wait_timer #(
    parameter int WAIT_CYCLES = 16,
    localparam int CNT_W      = (WAIT_CYCLES > 2) ? $clog2(WAIT_CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic expire_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign expire_o = run_i && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R7

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !clear_i) |=> $stable(cnt_q)); // R7

endmodule

// File: rtl/tt_fsm.sv
module tt_fsm
    import tt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      auto_hot_i,
    input  logic      demand_i,
    input  logic      expire_i,
    output tt_state_e state_o,
    output logic      timer_clr_o,
    output logic      timer_run_o,
    output logic      throttle_o,
    output logic      step_down_o,
    output logic      step_up_o,
    output logic      irq_o,
    output logic      irq_dir_o
);

    tt_state_e state_q, state_d;
    logic      down_evt, up_evt;

    // Next-state and transition events
    always_comb begin
        state_d     = state_q;
        timer_clr_o = 1'b0;
        down_evt    = 1'b0;
        up_evt      = 1'b0;
        unique case (state_q)
            TT_RUN: begin
                if (auto_hot_i) begin
                    state_d     = TT_AUTO;
                    timer_clr_o = 1'b1;
                    down_evt    = 1'b1;
                end else if (demand_i) begin
                    state_d  = TT_DEMAND;
                    down_evt = 1'b1;
                end
            end
            TT_DEMAND: begin
                if (auto_hot_i) begin
                    state_d     = TT_AUTO;
                    timer_clr_o = 1'b1;
                end else if (!demand_i) begin
                    state_d = TT_RUN;
                    up_evt  = 1'b1;
                end
            end
            TT_AUTO: begin
                if (expire_i && !auto_hot_i) begin
                    if (demand_i) begin
                        state_d = TT_DEMAND;
                    end else begin
                        state_d = TT_RUN;
                        up_evt  = 1'b1;
                    end
                end
            end
            default: state_d = TT_RUN;
        endcase
    end

    assign timer_run_o = (state_q == TT_AUTO);
    assign state_o     = state_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TT_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            throttle_o  <= 1'b0;
            step_down_o <= 1'b0;
            step_up_o   <= 1'b0;
            irq_o       <= 1'b0;
            irq_dir_o   <= 1'b0;
        end else begin
            throttle_o  <= (state_d != TT_RUN);
            step_down_o <= down_evt;
            step_up_o   <= up_evt;
            irq_o       <= down_evt || up_evt;
            if (down_evt) begin
                irq_dir_o <= 1'b1;
            end else if (up_evt) begin
                irq_dir_o <= 1'b0;
            end
        end
    end

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_down_o && step_up_o)); // R11

    AST_DOWN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        step_down_o |=> !step_down_o); // R11

    AST_UP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        step_up_o |=> !step_up_o); // R11

    AST_DOWN_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        step_down_o |-> (irq_dir_o && throttle_o && irq_o)); // R10

    AST_UP_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        step_up_o |-> (!irq_dir_o && !throttle_o && irq_o)); // R10

    AST_RISE_HAS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(throttle_o) |-> step_down_o); // R2

    AST_FALL_HAS_UP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(throttle_o) |-> step_up_o); // R4

endmodule

// File: rtl/thermal_throttle_ctl.sv
module thermal_throttle_ctl
    import tt_pkg::*;
#(
    parameter int WAIT_CYCLES = 16,
    parameter int CTL_W       = 8,
    parameter int DEMAND_BIT  = 4,
    localparam int IDX_W      = (CTL_W > 1) ? $clog2(CTL_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hot_i,
    input  logic             auto_en_i,
    input  logic             ctl_wr_i,
    input  logic [IDX_W-1:0] ctl_bit_i,
    input  logic             ctl_val_i,
    output logic             throttle_o,
    output logic             step_down_o,
    output logic             step_up_o,
    output logic             irq_o,
    output logic             irq_dir_o
);

    logic      auto_hot;
    logic      demand_eff;
    logic      timer_clr;
    logic      timer_run;
    logic      expire;
    tt_state_e state;

    assign auto_hot = hot_i && auto_en_i;

    tt_demand_reg #(
        .CTL_W      (CTL_W),
        .DEMAND_BIT (DEMAND_BIT)
    ) u_demand (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (ctl_wr_i),
        .bit_i        (ctl_bit_i),
        .val_i        (ctl_val_i),
        .demand_eff_o (demand_eff)
    );

    tt_wait_timer #(
        .WAIT_CYCLES (WAIT_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (timer_clr),
        .run_i    (timer_run),
        .expire_o (expire)
    );

    tt_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .auto_hot_i  (auto_hot),
        .demand_i    (demand_eff),
        .expire_i    (expire),
        .state_o     (state),
        .timer_clr_o (timer_clr),
        .timer_run_o (timer_run),
        .throttle_o  (throttle_o),
        .step_down_o (step_down_o),
        .step_up_o   (step_up_o),
        .irq_o       (irq_o),
        .irq_dir_o   (irq_dir_o)
    );

    AST_AUTO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TT_RUN && hot_i && auto_en_i) |=> (step_down_o && throttle_o)); // R5

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_run && !expire) |=> (throttle_o && !step_up_o)); // R6

    AST_HOT_RENEW: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && hot_i && auto_en_i) |=> (throttle_o && !irq_o)); // R8

endmodule

// File: tb/thermal_throttle_ctl_tb_top.sv
`timescale 1ns/1ps
module thermal_throttle_ctl_tb_top;

    localparam int W = 16;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       hot, auto_en, wr, val;
    logic [2:0] bidx;
    logic       throttle, sdown, sup, irq, irq_dir;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc_count = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_mode;     // 0 unthrottled, 1 software-held, 2 temperature-held
    int m_elapsed;
    bit m_demand, m_throttle, m_down, m_up, m_irq, m_dir;

    always #2 clk = ~clk;   // 250 MHz

    thermal_throttle_ctl #(.WAIT_CYCLES(W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .hot_i       (hot),
        .auto_en_i   (auto_en),
        .ctl_wr_i    (wr),
        .ctl_bit_i   (bidx),
        .ctl_val_i   (val),
        .throttle_o  (throttle),
        .step_down_o (sdown),
        .step_up_o   (sup),
        .irq_o       (irq),
        .irq_dir_o   (irq_dir)
    );

    task automatic check_bit(input string what, input string req, input bit act, input bit exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", req, what, cyc_count, act, exp);
        end
    endtask

    task automatic model_edge();
        bit want_auto, dem;
        want_auto = hot && auto_en && rst_n;
        dem = (wr && bidx == 3'd4) ? val : m_demand;
        m_down = 0;
        m_up = 0;
        if (!rst_n) begin
            m_mode = 0; m_elapsed = 0; m_demand = 0; m_dir = 0;
        end else begin
            if (m_mode == 0) begin
                if (want_auto) begin m_mode = 2; m_elapsed = 0; m_down = 1; end
                else if (dem) begin m_mode = 1; m_down = 1; end
            end else if (m_mode == 1) begin
                if (want_auto) begin m_mode = 2; m_elapsed = 0; end
                else if (!dem) begin m_mode = 0; m_up = 1; end
            end else begin
                m_elapsed++;
                if (m_elapsed == W) begin
                    m_elapsed = 0;
                    if (!want_auto) begin
                        if (dem) m_mode = 1;
                        else begin m_mode = 0; m_up = 1; end
                    end
                end
            end
            m_demand = dem;
            if (m_down) m_dir = 1;
            else if (m_up) m_dir = 0;
        end
        m_throttle = (m_mode != 0);
        m_irq = m_down | m_up;
    endtask

    // One clock: inputs are already driven; advance model at the edge, compare at the falling edge.
    task automatic tick();
        @(posedge clk);
        model_edge();
        cyc_count++;
        @(negedge clk);
        check_bit("throttle_o",  cur_req, throttle, m_throttle);
        check_bit("step_down_o", cur_req, sdown,    m_down);
        check_bit("step_up_o",   cur_req, sup,      m_up);
        check_bit("irq_o",       "R10",   irq,      m_irq);
        check_bit("irq_dir_o",   "R10",   irq_dir,  m_dir);
        check_bit("pulse exclusion", "R11", bit'(sdown && sup), 1'b0);
    endtask

    task automatic idle(input int n);
        wr = 0;
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic write_bit(input logic [2:0] idx, input logic v);
        wr = 1; bidx = idx; val = v;
        tick();
        wr = 0; bidx = 3'd0; val = 0;
    endtask

    initial begin
        rst_n = 0; hot = 0; auto_en = 0; wr = 0; bidx = 0; val = 0;
        m_mode = 0; m_elapsed = 0; m_demand = 0; m_throttle = 0;
        m_down = 0; m_up = 0; m_irq = 0; m_dir = 0;
        @(negedge clk);
        // R1: reset values, with stimulus pending
        cur_req = "R1";
        hot = 1; auto_en = 1;
        for (int i = 0; i < 3; i++) tick();
        hot = 0; auto_en = 0;
        rst_n = 1;
        idle(2);

        // R5: hot with automatic mode disabled is ignored
        cur_req = "R5";
        hot = 1; auto_en = 0;
        idle(5);
        hot = 0;

        // R3: writes to other bit indices change nothing
        cur_req = "R3";
        for (int b = 0; b < 8; b++) if (b != 4) write_bit(3'(b), 1'b1);
        idle(3);

        // R2: demand bit set throttles immediately; hot level irrelevant
        cur_req = "R2";
        write_bit(3'd4, 1'b1);
        idle(4);
        // R3: clearing other bits while throttled has no effect
        cur_req = "R3";
        for (int b = 0; b < 8; b++) if (b != 4) write_bit(3'(b), 1'b0);
        // R4: clearing demand ends software throttling
        cur_req = "R4";
        write_bit(3'd4, 1'b0);
        idle(3);

        // R7: one hot cycle gives exactly W cycles of throttling then step up
        cur_req = "R7";
        auto_en = 1; hot = 1;
        tick();
        hot = 0;
        idle(W + 4);

        // R8: still hot at expiry renews the wait
        cur_req = "R8";
        hot = 1;
        idle(W + 5);
        hot = 0;
        idle(2 * W + 3);

        // R6: clearing demand during automatic ownership has no effect
        cur_req = "R6";
        hot = 1; tick(); hot = 0;
        idle(3);
        write_bit(3'd4, 1'b0);
        idle(W + 3);

        // R9: demand set during automatic wait keeps throttling at cool expiry
        cur_req = "R9";
        hot = 1; tick(); hot = 0;
        idle(2);
        write_bit(3'd4, 1'b1);
        idle(W + 4);
        write_bit(3'd4, 1'b0);
        idle(3);

        // R6: hot during software throttling moves ownership silently
        cur_req = "R6";
        write_bit(3'd4, 1'b1);
        idle(3);
        hot = 1; tick(); hot = 0;
        write_bit(3'd4, 1'b0);
        idle(W + 4);

        // R10: direction status holds across quiet cycles
        cur_req = "R10";
        write_bit(3'd4, 1'b1);
        idle(5);
        write_bit(3'd4, 1'b0);
        idle(5);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule